// File: doc/BRIEF.md
# Supervisor Operation Intercept Filter

This block sits next to the instruction decoder and decides, one instruction at a time, whether a supervisor-level operation must be turned into an illegal-instruction exception because machine mode has asked to intercept it. Three intercept controls are held here: one for address-translation management (accesses to the translation-base CSR and the two translation-fence instructions), one for the supervisor return instruction, and one for wait-for-interrupt. Each control gates only its own group of operations.

The decoder presents an instruction-valid strobe with one-hot decode flags, the current privilege level and a pending-interrupt indication. The filter answers with a registered illegal-instruction request one cycle later. A wait-for-interrupt that the decoder holds stalled in a mode below machine mode is timed by a bounded cycle counter. If the wait-intercept control is set and the counter runs out before an interrupt becomes pending, the wait traps. The three controls are written through a plain write strobe and legalised: a control whose privilege mode does not exist always reads back as zero.

Top module: `priv_trap_filter`

## Requirements
- R1: In the cycle after reset, `illegal_instr`, `tvm_q`, `tsr_q` and `tw_q` are all 0.
- R2: If `instr_valid` is high in supervisor mode (`priv_mode` = 2'b01) with `tvm_q` = 1 and any of `is_satp_access`, `is_sfence_vma` or `is_sinval_vma`, then `illegal_instr` is 1 in the following cycle.
- R3: With `tvm_q` = 0, those three operations in supervisor mode never raise `illegal_instr`.
- R4: With `tsr_q` = 1, a valid `is_sret` in supervisor mode raises `illegal_instr` in the following cycle. With `tsr_q` = 0, it does not.
- R5: In machine mode (`priv_mode` = 2'b11), no operation raises `illegal_instr`, whatever the control bits are and however long a wait lasts.
- R6: A write with `ctl_we` = 1 loads `wr_tvm`, `wr_tsr` and `wr_tw`. The new values are visible on the outputs the next cycle. While `s_mode_present` = 0, `tvm_q` and `tsr_q` read 0 regardless of what was written.
- R7: When no mode below machine exists (`s_mode_present` = 0 and parameter `HAS_U_MODE` = 0), `tw_q` reads 0 regardless of what was written.
- R8: With `tw_q` = 1, a valid `is_wfi` held in supervisor or user mode (`priv_mode` 2'b01 or 2'b00) with no pending interrupt raises `illegal_instr` after exactly `WFI_LIMIT` clock edges of waiting, and not after `WFI_LIMIT`-1.
- R9: A pending interrupt (`irq_pending` = 1), or the wait strobe dropping, clears the wait counter. The next timeout then needs a full `WFI_LIMIT` further edges.
- R10: With `tw_q` = 0, a wait-for-interrupt never raises `illegal_instr`, however long it is held.
- R11: `illegal_instr` is a single-cycle pulse. It is never high in two consecutive cycles, even if a trapping instruction is held valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_mode | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| s_mode_present | input | 1 | Supervisor mode is implemented |
| ctl_we | input | 1 | Write strobe for the three intercept controls |
| wr_tvm | input | 1 | Write value for the translation-management intercept |
| wr_tsr | input | 1 | Write value for the supervisor-return intercept |
| wr_tw | input | 1 | Write value for the wait-timeout intercept |
| instr_valid | input | 1 | A decoded instruction is presented (held while stalled) |
| is_satp_access | input | 1 | Instruction reads or writes the translation-base CSR |
| is_sfence_vma | input | 1 | Instruction is the translation fence |
| is_sinval_vma | input | 1 | Instruction is the fine-grained translation invalidate |
| is_sret | input | 1 | Instruction is the supervisor return |
| is_wfi | input | 1 | Instruction is wait-for-interrupt |
| irq_pending | input | 1 | An interrupt is pending, which completes a wait |
| illegal_instr | output | 1 | Registered illegal-instruction request pulse |
| tvm_q | output | 1 | Legalised translation-management intercept bit |
| tsr_q | output | 1 | Legalised supervisor-return intercept bit |
| tw_q | output | 1 | Legalised wait-timeout intercept bit |

## Verification
The bench builds the filter with `WFI_LIMIT` = 8 and `HAS_U_MODE` = 0. The short limit brings the exact timeout edge, the counter restart after an interrupt and repeated wait windows within a few dozen cycles. Without user mode, clearing `s_mode_present` leaves no mode below machine, so the forced-zero legalisation of all three controls can be seen at the outputs. Machine-mode immunity is exercised with waits held well beyond the limit.

// File: rtl/trap_filter_pkg.sv
package trap_filter_pkg;
  typedef enum logic [1:0] {
    PRIV_USER  = 2'b00,
    PRIV_SUPER = 2'b01,
    PRIV_RSVD  = 2'b10,
    PRIV_MACH  = 2'b11
  } priv_e;
endpackage

// File: rtl/intercept_ctl.sv
module intercept_ctl #(
  parameter bit HAS_U_MODE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic s_present,
  input  logic we,
  input  logic d_tvm,
  input  logic d_tsr,
  input  logic d_tw,
  output logic tvm_q,
  output logic tsr_q,
  output logic tw_q
);
  logic lower_present;

  generate
    if (HAS_U_MODE) begin : g_with_user
      assign lower_present = 1'b1;
    end else begin : g_no_user
      assign lower_present = s_present;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      tvm_q <= 1'b0;
      tsr_q <= 1'b0;
      tw_q  <= 1'b0;
    end else begin
      tvm_q <= (we ? d_tvm : tvm_q) & s_present;
      tsr_q <= (we ? d_tsr : tsr_q) & s_present;
      tw_q  <= (we ? d_tw  : tw_q)  & lower_present;
    end
  end

  // R6
  s_legal_chk: assert property (@(posedge clk) disable iff (rst)
    !s_present |=> (!tvm_q && !tsr_q));

  // R7
  tw_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (!s_present && !HAS_U_MODE) |=> !tw_q);
endmodule

// File: rtl/wfi_timer.sv
module wfi_timer #(
  parameter int WFI_LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic waiting,
  output logic timeout
);
  localparam int CW = $clog2(WFI_LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(WFI_LIMIT - 1);

  logic [CW-1:0] cnt;

  assign timeout = waiting && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !waiting || timeout) cnt <= '0;
    else                            cnt <= cnt + 1'b1;
  end

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    !waiting |=> (cnt == '0));

  // R8
  bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/trap_decide.sv
module trap_decide
  import trap_filter_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] priv_mode,
  input  logic       instr_valid,
  input  logic       vm_op,
  input  logic       is_sret,
  input  logic       tvm,
  input  logic       tsr,
  input  logic       wfi_timeout,
  output logic       illegal_q
);
  logic in_super;
  logic cause;

  assign in_super = (priv_mode == PRIV_SUPER);
  assign cause    = (instr_valid && in_super && ((tvm && vm_op) || (tsr && is_sret)))
                  || wfi_timeout;

  always_ff @(posedge clk) begin
    if (rst) illegal_q <= 1'b0;
    else     illegal_q <= cause && !illegal_q;
  end

  // R11
  pulse_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_q |=> !illegal_q);

  // R5
  mach_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (priv_mode == PRIV_MACH) |=> !illegal_q);

  // R2
  tvm_trap_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && in_super && tvm && vm_op && !illegal_q) |=> illegal_q);

  // R3
  tvm_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && in_super && !tvm && !is_sret && !wfi_timeout) |=> !illegal_q);
endmodule

// File: rtl/priv_trap_filter.sv
module priv_trap_filter
  import trap_filter_pkg::*;
#(
  parameter int WFI_LIMIT  = 1024,
  parameter bit HAS_U_MODE = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] priv_mode,
  input  logic       s_mode_present,
  input  logic       ctl_we,
  input  logic       wr_tvm,
  input  logic       wr_tsr,
  input  logic       wr_tw,
  input  logic       instr_valid,
  input  logic       is_satp_access,
  input  logic       is_sfence_vma,
  input  logic       is_sinval_vma,
  input  logic       is_sret,
  input  logic       is_wfi,
  input  logic       irq_pending,
  output logic       illegal_instr,
  output logic       tvm_q,
  output logic       tsr_q,
  output logic       tw_q
);
  logic vm_op;
  logic waiting;
  logic timeout;

  assign vm_op   = is_satp_access | is_sfence_vma | is_sinval_vma;
  assign waiting = instr_valid && is_wfi && !irq_pending && tw_q
                && (priv_mode != PRIV_MACH);

  intercept_ctl #(.HAS_U_MODE(HAS_U_MODE)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .s_present (s_mode_present),
    .we        (ctl_we),
    .d_tvm     (wr_tvm),
    .d_tsr     (wr_tsr),
    .d_tw      (wr_tw),
    .tvm_q     (tvm_q),
    .tsr_q     (tsr_q),
    .tw_q      (tw_q)
  );

  wfi_timer #(.WFI_LIMIT(WFI_LIMIT)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .waiting (waiting),
    .timeout (timeout)
  );

  trap_decide u_decide (
    .clk         (clk),
    .rst         (rst),
    .priv_mode   (priv_mode),
    .instr_valid (instr_valid),
    .vm_op       (vm_op),
    .is_sret     (is_sret),
    .tvm         (tvm_q),
    .tsr         (tsr_q),
    .wfi_timeout (timeout),
    .illegal_q   (illegal_instr)
  );

  // R10
  tw_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!tw_q && !(instr_valid && (priv_mode == PRIV_SUPER) && ((tvm_q && vm_op) || (tsr_q && is_sret))))
      |=> !illegal_instr);
endmodule

// File: tb/sim_priv_trap_filter.sv
`timescale 1ns/1ps
module sim_priv_trap_filter;
  localparam int LIM = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] priv_mode = 2'b11;
  logic s_mode_present = 1'b0;
  logic ctl_we = 1'b0, wr_tvm = 1'b0, wr_tsr = 1'b0, wr_tw = 1'b0;
  logic instr_valid = 1'b0, is_satp_access = 1'b0, is_sfence_vma = 1'b0;
  logic is_sinval_vma = 1'b0, is_sret = 1'b0, is_wfi = 1'b0, irq_pending = 1'b0;
  logic illegal_instr, tvm_q, tsr_q, tw_q;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  priv_trap_filter #(.WFI_LIMIT(LIM), .HAS_U_MODE(1'b0)) u0 (
    .clk(clk), .rst(rst), .priv_mode(priv_mode), .s_mode_present(s_mode_present),
    .ctl_we(ctl_we), .wr_tvm(wr_tvm), .wr_tsr(wr_tsr), .wr_tw(wr_tw),
    .instr_valid(instr_valid), .is_satp_access(is_satp_access),
    .is_sfence_vma(is_sfence_vma), .is_sinval_vma(is_sinval_vma),
    .is_sret(is_sret), .is_wfi(is_wfi), .irq_pending(irq_pending),
    .illegal_instr(illegal_instr), .tvm_q(tvm_q), .tsr_q(tsr_q), .tw_q(tw_q)
  );

  task automatic check(input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", what, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_instr();
    instr_valid = 0; is_satp_access = 0; is_sfence_vma = 0;
    is_sinval_vma = 0; is_sret = 0; is_wfi = 0; irq_pending = 0;
  endtask

  task automatic write_ctl(input logic t, input logic s, input logic w);
    ctl_we = 1; wr_tvm = t; wr_tsr = s; wr_tw = w;
    step();
    ctl_we = 0;
  endtask

  task automatic test_reset();
    check(illegal_instr, 1'b0, "R1 illegal after reset");
    check(tvm_q, 1'b0, "R1 tvm after reset");
    check(tsr_q, 1'b0, "R1 tsr after reset");
    check(tw_q,  1'b0, "R1 tw after reset");
  endtask

  task automatic test_legalise();
    s_mode_present = 0;
    write_ctl(1, 1, 1);
    check(tvm_q, 1'b0, "R6 tvm forced zero");
    check(tsr_q, 1'b0, "R6 tsr forced zero");
    check(tw_q,  1'b0, "R7 tw forced zero with no lower mode");
    s_mode_present = 1;
    write_ctl(1, 1, 1);
    check(tvm_q, 1'b1, "R6 tvm written");
    check(tsr_q, 1'b1, "R6 tsr written");
    check(tw_q,  1'b1, "R6 tw written");
  endtask

  task automatic test_vm_trap();
    priv_mode = 2'b01;
    for (int k = 0; k < 3; k++) begin
      instr_valid = 1;
      is_satp_access = (k == 0); is_sfence_vma = (k == 1); is_sinval_vma = (k == 2);
      step();
      clear_instr();
      check(illegal_instr, 1'b1, $sformatf("R2 vm op %0d trapped", k));
      step();
      check(illegal_instr, 1'b0, $sformatf("R11 vm op %0d pulse ends", k));
    end
  endtask

  task automatic test_held_pulse();
    priv_mode = 2'b01;
    instr_valid = 1; is_satp_access = 1;
    step();
    check(illegal_instr, 1'b1, "R11 held op first cycle");
    step();
    check(illegal_instr, 1'b0, "R11 held op second cycle low");
    step();
    check(illegal_instr, 1'b1, "R11 held op third cycle");
    clear_instr();
    step();
  endtask

  task automatic test_machine();
    logic seen = 0;
    priv_mode = 2'b11;
    instr_valid = 1; is_satp_access = 1; is_sret = 1;
    step();
    check(illegal_instr, 1'b0, "R5 machine satp and sret");
    clear_instr();
    instr_valid = 1; is_wfi = 1;
    for (int i = 0; i < 3 * LIM; i++) begin
      step();
      seen |= illegal_instr;
    end
    check(seen, 1'b0, "R5 machine long wait");
    clear_instr();
    step();
  endtask

  task automatic test_sret();
    priv_mode = 2'b01;
    instr_valid = 1; is_sret = 1;
    step();
    clear_instr();
    check(illegal_instr, 1'b1, "R4 sret trapped");
    step();
    write_ctl(0, 0, 1);
    instr_valid = 1; is_sret = 1;
    step();
    clear_instr();
    check(illegal_instr, 1'b0, "R4 sret allowed with tsr clear");
    instr_valid = 1; is_satp_access = 1; is_sfence_vma = 1;
    step();
    clear_instr();
    check(illegal_instr, 1'b0, "R3 vm op allowed with tvm clear");
    instr_valid = 1; is_sinval_vma = 1;
    step();
    clear_instr();
    check(illegal_instr, 1'b0, "R3 sinval allowed with tvm clear");
  endtask

  task automatic wait_window(input logic [1:0] pm, input string tag);
    logic early = 0;
    priv_mode = pm;
    instr_valid = 1; is_wfi = 1;
    for (int i = 0; i < LIM - 1; i++) begin
      step();
      early |= illegal_instr;
    end
    check(early, 1'b0, {tag, " no trap before limit"});
    step();
    check(illegal_instr, 1'b1, {tag, " trap at limit"});
    clear_instr();
    step();
  endtask

  task automatic test_wfi_timeout();
    wait_window(2'b01, "R8 supervisor");
    wait_window(2'b00, "R8 user");
  endtask

  task automatic test_wfi_restart();
    logic early = 0;
    priv_mode = 2'b01;
    instr_valid = 1; is_wfi = 1;
    for (int i = 0; i < LIM - 2; i++) step();
    irq_pending = 1;
    step();
    irq_pending = 0;
    check(illegal_instr, 1'b0, "R9 interrupt completes wait");
    for (int i = 0; i < LIM - 1; i++) begin
      step();
      early |= illegal_instr;
    end
    check(early, 1'b0, "R9 counter restarted after interrupt");
    step();
    check(illegal_instr, 1'b1, "R9 full window after interrupt");
    clear_instr();
    instr_valid = 1; is_wfi = 1;
    for (int i = 0; i < LIM - 2; i++) step();
    clear_instr();
    step();
    instr_valid = 1; is_wfi = 1;
    early = 0;
    for (int i = 0; i < LIM - 1; i++) begin
      step();
      early |= illegal_instr;
    end
    check(early, 1'b0, "R9 counter restarted after strobe drop");
    step();
    check(illegal_instr, 1'b1, "R9 full window after strobe drop");
    clear_instr();
    step();
  endtask

  task automatic test_tw_off();
    logic seen = 0;
    write_ctl(0, 0, 0);
    priv_mode = 2'b01;
    instr_valid = 1; is_wfi = 1;
    for (int i = 0; i < 3 * LIM; i++) begin
      step();
      seen |= illegal_instr;
    end
    check(seen, 1'b0, "R10 wait never traps with tw clear");
    clear_instr();
    step();
  endtask

  initial begin
    @(negedge clk);
    step();
    rst = 0;
    step();
    test_reset();
    test_legalise();
    test_vm_trap();
    test_held_pulse();
    test_machine();
    test_sret();
    test_wfi_timeout();
    test_wfi_restart();
    test_tw_off();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule